// File: doc/BRIEF.md
# Power-Fail Store and Recall Controller

This block orders the transfers between a volatile SRAM array and the nonvolatile shadow copy kept beside it. Two already-synchronized supply flags feed it. One says the supply is above the switch threshold. The other says the supply has fallen below the reset level. The block also watches the host write strobe and accepts one-cycle software requests for a store or a recall. From these it drives the phase controls for the array, a busy flag that shuts out the host, a write-inhibit line, and a one-cycle completion pulse for each kind of operation.

A store runs in two steps: the shadow is erased, then it is programmed from the SRAM. A recall also runs in two steps: the SRAM is cleared, then the shadow contents are copied into it. A power-loss store happens only if the array holds writes that are not yet saved. A power-return recall happens only if the supply really fell to the reset level. Every phase length is a parameter counted in clock cycles.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset, busy_o and all four phase outputs are 0, the dirty flag is clear, and a recall is pending (power-on).
- R2: When vcc_ok_i falls while the block is idle, a store starts only if the dirty flag is set. With a clean array, no phase output is raised.
- R3: An accepted sw_store_req_i starts a store whether or not the dirty flag is set.
- R4: While vcc_ok_i is 0, wr_inhibit_o is 1, a host write has no effect on the array, and software store or recall requests are ignored.
- R5: Any cycle with vcc_low_i set (and at reset) latches a pending recall. The recall starts on the first idle cycle in which vcc_ok_i is 1. A dip that never sets vcc_low_i causes no recall.
- R6: A store raises erase_o for exactly STORE_CYC/2 cycles, then program_o for the remaining cycles, with no gap between them. store_done_o rises in the cycle after program_o falls.
- R7: A recall raises clear_o for exactly RECALL_CYC/2 cycles, then transfer_o for the remaining cycles. recall_done_o follows in the same way. A recall never changes the shadow copy.
- R8: busy_o is 1 in every phase cycle, and wr_inhibit_o is 1 whenever busy_o is 1. Host writes made during an operation have no effect.
- R9: A host write accepted while wr_inhibit_o is 0 sets the dirty flag. Completing a store or a recall clears it. A write in the completion cycle leaves the flag set.
- R10: Priority among starts is power-loss store, then power-return recall, then software store, then software recall. Requests that arrive while busy are dropped, not queued.
- R11: store_done_o and recall_done_o are pulses exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_ok_i | input | 1 | Supply is above the switch threshold (synchronized) |
| vcc_low_i | input | 1 | Supply is below the reset level (synchronized) |
| host_wr_i | input | 1 | Host write strobe toward the SRAM array |
| sw_store_req_i | input | 1 | One-cycle software store request |
| sw_recall_req_i | input | 1 | One-cycle software recall request |
| erase_o | output | 1 | Store phase 1: erase the shadow |
| program_o | output | 1 | Store phase 2: program the shadow from the SRAM |
| clear_o | output | 1 | Recall phase 1: clear the SRAM |
| transfer_o | output | 1 | Recall phase 2: copy the shadow into the SRAM |
| busy_o | output | 1 | An operation is in progress; host access is blocked |
| wr_inhibit_o | output | 1 | SRAM writes are blocked |
| store_done_o | output | 1 | One-cycle pulse when a store completes |
| recall_done_o | output | 1 | One-cycle pulse when a recall completes |

## Verification
The bench targets brown-outs on a clean array, where a design that ignores the dirty flag would wear the shadow with useless stores. It also targets shallow dips against deep ones: a design that recalls on every return would overwrite newer SRAM data, and one that forgets the pending request would come up with stale contents. A software store issued at the exact cycle the supply returns from a deep dip must lose to the recall. A store request made during a recall must vanish, and a queuing design would show an extra store. Writes attempted during low supply or during an operation must leave the modelled array untouched, and the phase lengths and ordering are measured on every operation.

// File: rtl/nvs_pkg.sv
// Shared types for the power-fail store/recall controller.
// Assumes: nothing; pure type definitions.
package nvs_pkg;

    // Sequencer state: idle or one of the four transfer phases
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ERASE = 3'd1,
        PH_PROG  = 3'd2,
        PH_CLEAR = 3'd3,
        PH_XFER  = 3'd4
    } nvs_phase_e;

    // Operation selected by the arbiter for this cycle
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_STORE  = 2'd1,
        OP_RECALL = 2'd2
    } nvs_op_e;

endpackage

// File: rtl/nvs_supply_mon.sv
// Supply monitor: detects loss of the above-switch flag and latches a
// pending recall whenever the supply reaches the reset level.
// Assumes: both flags are already synchronized to clk; vcc_low_i implies
// vcc_ok_i is low.
module nvs_supply_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok_i,
    input  logic vcc_low_i,
    input  logic recall_taken_i,
    output logic fall_o,
    output logic pend_o
);

    logic ok_prev_q;
    logic pend_q;

    // Remember last cycle's supply flag for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ok_prev_q <= 1'b0;
        else        ok_prev_q <= vcc_ok_i;
    end

    // Pending recall: set at power-on and at any reset-level dip, cleared when started
    always_ff @(posedge clk) begin
        if (!rst_n)              pend_q <= 1'b1;
        else if (vcc_low_i)      pend_q <= 1'b1;
        else if (recall_taken_i) pend_q <= 1'b0;
    end

    assign fall_o = ok_prev_q & ~vcc_ok_i;
    assign pend_o = pend_q;

    // R5
    pend_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_low_i && !vcc_ok_i) |=> pend_q);

endmodule

// File: rtl/nvs_dirty_track.sv
// Dirty tracker: records whether the SRAM was written since the last
// completed store or recall.
// Assumes: wr_acc_i is already qualified by the write inhibit.
module nvs_dirty_track (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_acc_i,
    input  logic clear_i,
    output logic dirty_o
);

    logic dirty_q;

    // Accepted write sets the flag; completion clears it; a write wins a tie
    always_ff @(posedge clk) begin
        if (!rst_n)        dirty_q <= 1'b0;
        else if (wr_acc_i) dirty_q <= 1'b1;
        else if (clear_i)  dirty_q <= 1'b0;
    end

    assign dirty_o = dirty_q;

    // R9
    dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc_i |=> dirty_q);

    // R9
    dirty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !wr_acc_i) |=> !dirty_q);

endmodule

// File: rtl/nvs_arbiter.sv
// Start arbiter: picks at most one operation to launch in an idle cycle.
// Priority: power-loss store, power-return recall, software store,
// software recall. Anything arriving while busy is dropped.
// Assumes: software request inputs are single-cycle pulses.
module nvs_arbiter
    import nvs_pkg::*;
(
    input  logic    idle_i,
    input  logic    vcc_ok_i,
    input  logic    fall_i,
    input  logic    dirty_i,
    input  logic    pend_i,
    input  logic    sw_store_i,
    input  logic    sw_recall_i,
    output nvs_op_e op_o,
    output logic    recall_taken_o
);

    logic auto_store;
    logic pwr_recall;
    logic sw_store_ok;
    logic sw_recall_ok;

    assign auto_store   = fall_i & dirty_i;
    assign pwr_recall   = pend_i & vcc_ok_i;
    assign sw_store_ok  = sw_store_i & vcc_ok_i;
    assign sw_recall_ok = sw_recall_i & vcc_ok_i;

    // Fixed-priority selection of the operation to start
    always_comb begin
        op_o           = OP_NONE;
        recall_taken_o = 1'b0;
        if (idle_i) begin
            if (auto_store) begin
                op_o = OP_STORE;
            end else if (pwr_recall) begin
                op_o           = OP_RECALL;
                recall_taken_o = 1'b1;
            end else if (sw_store_ok) begin
                op_o = OP_STORE;
            end else if (sw_recall_ok) begin
                op_o = OP_RECALL;
            end
        end
    end

endmodule

// File: rtl/nvs_phase_seq.sv
// Phase sequencer: steps a store through erase then program, or a recall
// through clear then transfer, each phase a fixed number of cycles, and
// emits a one-cycle completion pulse.
// Assumes: every phase length parameter is at least 1; op_i is OP_NONE
// unless the sequencer is idle.
module nvs_phase_seq
    import nvs_pkg::*;
#(
    parameter int ERASE_CYC = 1_000_000,
    parameter int PROG_CYC  = 1_000_000,
    parameter int CLEAR_CYC = 55_000,
    parameter int XFER_CYC  = 55_000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  nvs_op_e op_i,
    output logic    erase_o,
    output logic    program_o,
    output logic    clear_o,
    output logic    transfer_o,
    output logic    busy_o,
    output logic    store_done_o,
    output logic    recall_done_o
);

    localparam int MAX_SA = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAX_RA = (CLEAR_CYC > XFER_CYC) ? CLEAR_CYC : XFER_CYC;
    localparam int MAXL   = (MAX_SA > MAX_RA) ? MAX_SA : MAX_RA;
    localparam int CW     = $clog2(MAXL + 1);

    localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] PROG_LD  = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] CLEAR_LD = CW'(CLEAR_CYC - 1);
    localparam logic [CW-1:0] XFER_LD  = CW'(XFER_CYC - 1);

    nvs_phase_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           last;
    logic           sdone_q, rdone_q;

    assign last = (cnt_q == '0);

    // Next-state and counter reload for the phase walk
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_IDLE: begin
                if (op_i == OP_STORE) begin
                    state_d = PH_ERASE;
                    cnt_d   = ERASE_LD;
                end else if (op_i == OP_RECALL) begin
                    state_d = PH_CLEAR;
                    cnt_d   = CLEAR_LD;
                end
            end
            PH_ERASE: begin
                if (last) begin
                    state_d = PH_PROG;
                    cnt_d   = PROG_LD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_PROG: begin
                if (last) state_d = PH_IDLE;
                else      cnt_d   = cnt_q - 1'b1;
            end
            PH_CLEAR: begin
                if (last) begin
                    state_d = PH_XFER;
                    cnt_d   = XFER_LD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_XFER: begin
                if (last) state_d = PH_IDLE;
                else      cnt_d   = cnt_q - 1'b1;
            end
            default: begin
                state_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Completion pulses, raised in the first idle cycle after the last phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdone_q <= 1'b0;
            rdone_q <= 1'b0;
        end else begin
            sdone_q <= (state_q == PH_PROG) && last;
            rdone_q <= (state_q == PH_XFER) && last;
        end
    end

    assign erase_o       = (state_q == PH_ERASE);
    assign program_o     = (state_q == PH_PROG);
    assign clear_o       = (state_q == PH_CLEAR);
    assign transfer_o    = (state_q == PH_XFER);
    assign busy_o        = (state_q != PH_IDLE);
    assign store_done_o  = sdone_q;
    assign recall_done_o = rdone_q;

    // R6
    erase_to_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_o) |-> program_o);

    // R6
    prog_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(program_o) |-> store_done_o);

    // R7
    clear_to_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clear_o) |-> transfer_o);

    // R7
    xfer_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(transfer_o) |-> recall_done_o);

    // R11
    sdone_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_done_o |=> !store_done_o);

    // R11
    rdone_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_done_o |=> !recall_done_o);

endmodule

// File: rtl/nvs_ctrl.sv
// Power-fail store/recall controller top: ties the supply monitor, dirty
// tracker, start arbiter and phase sequencer together and derives the
// host-facing busy and write-inhibit signals.
// Assumes: supply flags are synchronized; STORE_CYC and RECALL_CYC >= 2.
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int STORE_CYC  = 2_000_000,
    parameter int RECALL_CYC = 110_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok_i,
    input  logic vcc_low_i,
    input  logic host_wr_i,
    input  logic sw_store_req_i,
    input  logic sw_recall_req_i,
    output logic erase_o,
    output logic program_o,
    output logic clear_o,
    output logic transfer_o,
    output logic busy_o,
    output logic wr_inhibit_o,
    output logic store_done_o,
    output logic recall_done_o
);

    localparam int ERASE_CYC = STORE_CYC / 2;
    localparam int PROG_CYC  = STORE_CYC - ERASE_CYC;
    localparam int CLEAR_CYC = RECALL_CYC / 2;
    localparam int XFER_CYC  = RECALL_CYC - CLEAR_CYC;

    logic    fall;
    logic    pend;
    logic    dirty;
    logic    recall_taken;
    logic    wr_acc;
    nvs_op_e op;

    assign wr_inhibit_o = ~vcc_ok_i | busy_o;
    assign wr_acc       = host_wr_i & ~wr_inhibit_o;

    nvs_supply_mon u_mon (
        .clk            (clk),
        .rst_n          (rst_n),
        .vcc_ok_i       (vcc_ok_i),
        .vcc_low_i      (vcc_low_i),
        .recall_taken_i (recall_taken),
        .fall_o         (fall),
        .pend_o         (pend)
    );

    nvs_dirty_track u_dirty (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_acc_i (wr_acc),
        .clear_i  (store_done_o | recall_done_o),
        .dirty_o  (dirty)
    );

    nvs_arbiter u_arb (
        .idle_i         (~busy_o),
        .vcc_ok_i       (vcc_ok_i),
        .fall_i         (fall),
        .dirty_i        (dirty),
        .pend_i         (pend),
        .sw_store_i     (sw_store_req_i),
        .sw_recall_i    (sw_recall_req_i),
        .op_o           (op),
        .recall_taken_o (recall_taken)
    );

    nvs_phase_seq #(
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC),
        .CLEAR_CYC (CLEAR_CYC),
        .XFER_CYC  (XFER_CYC)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_i          (op),
        .erase_o       (erase_o),
        .program_o     (program_o),
        .clear_o       (clear_o),
        .transfer_o    (transfer_o),
        .busy_o        (busy_o),
        .store_done_o  (store_done_o),
        .recall_done_o (recall_done_o)
    );

    // R8
    busy_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (erase_o || clear_o));

    // R2
    clean_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !dirty && !busy_o) |=> !erase_o);

    // R4
    low_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_ok_i && !busy_o && !(fall && dirty)) |=> !busy_o);

endmodule

// File: tb/tb_nvs_ctrl.sv
`timescale 1ns/100ps
module tb_nvs_ctrl;

    localparam int SC    = 24;
    localparam int RC    = 10;
    localparam int E_LEN = SC / 2;
    localparam int P_LEN = SC - E_LEN;
    localparam int C_LEN = RC / 2;
    localparam int T_LEN = RC - C_LEN;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ok = 1'b0, low = 1'b1, wr = 1'b0, sws = 1'b0, swr = 1'b0;
    logic [3:0] waddr = '0;
    logic [7:0] wdata = '0;
    logic erase_o, program_o, clear_o, transfer_o, busy_o, wr_inhibit_o;
    logic store_done_o, recall_done_o;

    int nchk = 0, nerr = 0;
    int n_store = 0, n_recall = 0, exp_store = 0, exp_recall = 0;

    // behavioural array pair driven by the design's phase outputs
    logic [7:0] m_sram [DEPTH];
    logic [7:0] m_shad [DEPTH];
    // reference model of the same pair
    logic [7:0] r_sram [DEPTH];
    logic [7:0] r_shad [DEPTH];
    bit r_dirty = 1'b0;

    always #2.5 clk = ~clk;

    nvs_ctrl #(.STORE_CYC(SC), .RECALL_CYC(RC)) dut (
        .clk(clk), .rst_n(rst_n), .vcc_ok_i(ok), .vcc_low_i(low),
        .host_wr_i(wr), .sw_store_req_i(sws), .sw_recall_req_i(swr),
        .erase_o(erase_o), .program_o(program_o), .clear_o(clear_o),
        .transfer_o(transfer_o), .busy_o(busy_o), .wr_inhibit_o(wr_inhibit_o),
        .store_done_o(store_done_o), .recall_done_o(recall_done_o)
    );

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        nchk++;
        if (!cond) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // phase-length and ordering monitor plus array model
    int el = 0, pl = 0, cl = 0, tl = 0;
    logic pe = 0, pp = 0, pc = 0, pt = 0, psd = 0, prd = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (erase_o) el++;
            else if (pe) begin
                chk(el == E_LEN, "R6 erase length", el, E_LEN);
                chk(program_o, "R6 program follows erase", program_o, 1);
                el = 0;
            end
            if (program_o) pl++;
            else if (pp) begin
                chk(pl == P_LEN, "R6 program length", pl, P_LEN);
                chk(store_done_o, "R6 store done after program", store_done_o, 1);
                pl = 0;
            end
            if (clear_o) cl++;
            else if (pc) begin
                chk(cl == C_LEN, "R7 clear length", cl, C_LEN);
                chk(transfer_o, "R7 transfer follows clear", transfer_o, 1);
                cl = 0;
            end
            if (transfer_o) tl++;
            else if (pt) begin
                chk(tl == T_LEN, "R7 transfer length", tl, T_LEN);
                chk(recall_done_o, "R7 recall done after transfer", recall_done_o, 1);
                tl = 0;
            end
            if (store_done_o && psd) chk(0, "R11 store done width", 2, 1);
            if (recall_done_o && prd) chk(0, "R11 recall done width", 2, 1);
            if (busy_o && !wr_inhibit_o) chk(0, "R8 inhibit while busy", 0, 1);
            if (wr && !wr_inhibit_o) m_sram[waddr] = wdata;
            if (clear_o && !pc) for (int i = 0; i < DEPTH; i++) m_sram[i] = 8'h00;
            if (store_done_o) begin
                for (int i = 0; i < DEPTH; i++) m_shad[i] = m_sram[i];
                n_store++;
            end
            if (recall_done_o) begin
                for (int i = 0; i < DEPTH; i++) m_sram[i] = m_shad[i];
                n_recall++;
            end
            pe = erase_o; pp = program_o; pc = clear_o; pt = transfer_o;
            psd = store_done_o; prd = recall_done_o;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic settle();
        tick(SC + RC + 12);
    endtask

    function automatic bit auto_store_due(input bit dirty);
        return dirty;
    endfunction

    task automatic ref_store();
        for (int i = 0; i < DEPTH; i++) r_shad[i] = r_sram[i];
        r_dirty = 1'b0;
        exp_store++;
    endtask

    task automatic ref_recall();
        for (int i = 0; i < DEPTH; i++) r_sram[i] = r_shad[i];
        r_dirty = 1'b0;
        exp_recall++;
    endtask

    task automatic compare(input string req);
        int bad_s, bad_h;
        bad_s = 0; bad_h = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_sram[i] !== r_sram[i]) bad_s++;
            if (m_shad[i] !== r_shad[i]) bad_h++;
        end
        chk(n_store == exp_store, {req, " store count"}, n_store, exp_store);
        chk(n_recall == exp_recall, {req, " recall count"}, n_recall, exp_recall);
        chk(bad_s == 0, {req, " sram contents"}, bad_s, 0);
        chk(bad_h == 0, {req, " shadow contents"}, bad_h, 0);
    endtask

    // host write; the reference accepts it only when the bench expects no inhibit
    task automatic host_write(input logic [3:0] a, input logic [7:0] d, input bit accept);
        waddr = a; wdata = d; wr = 1'b1;
        tick(1);
        wr = 1'b0;
        if (accept) begin
            r_sram[a] = d;
            r_dirty = 1'b1;
        end
    endtask

    task automatic brownout(input bit deep);
        bit st;
        st = auto_store_due(r_dirty);
        ok = 1'b0;
        if (deep) low = 1'b1;
        tick(4);
        low = 1'b0;
        tick(1);
        ok = 1'b1;
        if (st) ref_store();
        if (deep) ref_recall();
        settle();
    endtask

    task automatic pulse_sw(input bit is_store);
        if (is_store) sws = 1'b1; else swr = 1'b1;
        tick(1);
        sws = 1'b0; swr = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) begin
            r_shad[i] = 8'(i * 7 + 3);
            m_shad[i] = 8'(i * 7 + 3);
            r_sram[i] = 8'hAA;
            m_sram[i] = 8'hAA;
        end
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk(!busy_o, "R1 busy after reset", busy_o, 0);
        chk({erase_o, program_o, clear_o, transfer_o} == 4'b0, "R1 phases after reset",
            {erase_o, program_o, clear_o, transfer_o}, 0);
        // R4: low supply blocks writes and software requests
        chk(wr_inhibit_o, "R4 inhibit at low supply", wr_inhibit_o, 1);
        host_write(4'd1, 8'h55, 1'b0);
        pulse_sw(1'b1);
        pulse_sw(1'b0);
        tick(SC);
        compare("R4 low supply");
        // R5: power-on recall starts when the supply returns
        low = 1'b0;
        tick(1);
        ok = 1'b1;
        tick(1);
        chk(busy_o && clear_o, "R5 power-on recall start", {busy_o, clear_o}, 3);
        ref_recall();
        // R8: write during the recall is ignored
        host_write(4'd2, 8'h99, 1'b0);
        settle();
        compare("R5 R7 R8 power-on recall");
        // R2 R5: shallow dip with a clean array: nothing happens
        brownout(1'b0);
        compare("R2 R5 clean shallow dip");
        // R2 R9: writes make it dirty, dip stores, no recall
        host_write(4'd3, 8'h31, 1'b1);
        host_write(4'd9, 8'hC4, 1'b1);
        brownout(1'b0);
        compare("R2 R9 dirty shallow dip");
        // R3: software store with clean array still runs
        pulse_sw(1'b1);
        ref_store();
        settle();
        compare("R3 clean software store");
        // R10: deep dip, software store at the return cycle loses to recall
        ok = 1'b0; low = 1'b1;
        tick(3);
        low = 1'b0;
        tick(1);
        ok = 1'b1; sws = 1'b1;
        tick(1);
        sws = 1'b0;
        chk(clear_o && !erase_o, "R10 recall beats software store",
            {clear_o, erase_o}, 2);
        ref_recall();
        settle();
        compare("R10 priority");
        // R10: request while busy is dropped; R7 recall keeps shadow
        host_write(4'd5, 8'h77, 1'b1);
        pulse_sw(1'b0);
        tick(3);
        pulse_sw(1'b1);
        ref_recall();
        settle();
        compare("R7 R10 busy drop");
        // random mix
        for (int k = 0; k < 60; k++) begin
            int op;
            op = int'($urandom_range(0, 7));
            case (op)
                0, 1, 2: host_write(4'($urandom_range(0, DEPTH - 1)), 8'($urandom), 1'b1);
                3: brownout(1'b0);
                4: brownout(1'b1);
                5: begin pulse_sw(1'b1); ref_store(); settle(); end
                6: begin pulse_sw(1'b0); ref_recall(); settle(); end
                default: tick(3);
            endcase
            if (op >= 3 && op <= 6) compare("R2 R3 R5 R9 random");
        end
        settle();
        compare("R2 R5 R9 final");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule